// File: doc/BRIEF.md
# Dual-Window Indirect Register Bridge

This bridge lets a host on a narrow memory-mapped bus reach two internal register spaces that are too large to map directly. Each space has its own window made of three bus registers: an address latch, a data port and a control register. The host first places a 16-bit internal address in a window's address latch. It then uses that window's data port: a write goes straight through to the internal register, and a read goes through a one-deep read buffer. The first data read starts the internal fetch and returns whatever the buffer held before. A second data read returns the value just fetched. Host software writes each address twice and reads each data value twice; the bridge accepts both without side effects.

Every bus access gets a response one cycle later. When the error-enable bit of a window's control register is set, a failed internal access or an access to an undefined offset returns a bus error. The internal side of each window is a plain strobe interface: address, write data, write strobe, read strobe, read data and a failure flag, all sampled in the cycle of the strobe.

Top module: `ibr_dual_window`

## Requirements
- R1: After reset, every address latch, read buffer and error-enable bit is zero, so reads of any address, data or control offset return 0.
- R2: Window w occupies byte offsets 16*w (address latch), 16*w+4 (data port) and 16*w+8 (control). A write to the address latch stores bits 15:0 of the write data and raises no internal strobe, so a repeated write has no side effect. A read of it returns the latched value zero-extended.
- R3: A write to the data port raises that window's write strobe for exactly the cycle of the bus request, with the latched internal address and the bus write data.
- R4: A read of the data port raises that window's read strobe in the request cycle with the latched address. The response carries the buffer's previous contents, and the buffer then takes the internal read data.
- R5: A second consecutive data-port read returns the internal value fetched by the first.
- R6: Every bus request is acknowledged exactly one cycle later. With no acknowledge, the response data and the error flag are zero.
- R7: The control register stores only bit 15 (error enable). A read of it returns that bit in position 15 and zero elsewhere.
- R8: A data-port access whose internal failure flag is high returns a bus error only when the window's error-enable bit is set.
- R9: Undefined offsets read as zero, and writes to them change nothing. Undefined offsets are the unused slot at +12, unaligned byte addresses, and any offset above the last window. Such an access signals an error only when error enable is set: the window's own bit inside a window, any window's bit beyond the last window.
- R10: The windows keep separate address latches, buffers and enables, so interleaved accesses to both return each window's own data. At most one internal strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte offset of the access |
| bus_wdata | input | DW | Bus write data |
| bus_ack | output | 1 | Response valid, one cycle after the request |
| bus_rdata | output | DW | Read response data |
| bus_err | output | 1 | Error response |
| reg_addr | output | NWIN x IAW | Internal address per window |
| reg_wdata | output | NWIN x DW | Internal write data per window |
| reg_we | output | NWIN | Internal write strobe per window |
| reg_re | output | NWIN | Internal read strobe per window |
| reg_rdata | input | NWIN x DW | Internal read data per window |
| reg_fail | input | NWIN | Internal access failure per window |

## Verification
The main sweep visits forty internal addresses in each window. Each address is written with junk in the upper half, which tells apart truncating to 16 bits from keeping the full word. The internal model's read data encodes both the window and the address, so a value from the wrong window, a stale buffer, or a response off by one read all give distinct mismatches. A sweep over every byte offset of the bus range separates the defined slots from the undefined ones under both error-enable settings. Interleaved reads across the two windows expose any buffer or latch shared between them.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    // Bit of the control register that enables error responses
    localparam int ERR_EN_BIT = 15;

    // Register slot inside one 16-byte window
    typedef enum logic [1:0] {
        SLOT_ADDR = 2'd0,
        SLOT_DATA = 2'd1,
        SLOT_CTRL = 2'd2,
        SLOT_NONE = 2'd3
    } slot_e;

    // Decoded access aimed at one window
    typedef struct packed {
        logic  valid;
        logic  we;
        slot_e slot;
    } win_cmd_t;

    // Map the low nibble of a byte offset to a slot; unaligned is undefined
    function automatic slot_e slot_of(input logic [3:0] off);
        case (off)
            4'h0:    return SLOT_ADDR;
            4'h4:    return SLOT_DATA;
            4'h8:    return SLOT_CTRL;
            default: return SLOT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
    import ibr_pkg::*;
#(
    parameter int BUS_AW = 8,
    parameter int NWIN   = 2
) (
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [BUS_AW-1:0]     bus_addr,
    output win_cmd_t [NWIN-1:0]   cmd,
    output logic                  out_of_range
);
    localparam int WIN_IW = BUS_AW - 4;

    logic  [WIN_IW-1:0] win_idx;
    slot_e              slot;
    logic  [NWIN-1:0]   hit;

    assign win_idx = bus_addr[BUS_AW-1:4];
    assign slot    = slot_of(bus_addr[3:0]);

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign hit[w]       = bus_sel && (win_idx == WIN_IW'(w));
        assign cmd[w].valid = hit[w];
        assign cmd[w].we    = bus_wr;
        assign cmd[w].slot  = slot;
    end

    assign out_of_range = bus_sel && (hit == '0);

endmodule

// File: rtl/ibr_window.sv
module ibr_window
    import ibr_pkg::*;
#(
    parameter int IAW = 16,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  win_cmd_t       cmd,
    input  logic [DW-1:0]  bus_wdata,
    output logic [IAW-1:0] int_addr,
    output logic [DW-1:0]  int_wdata,
    output logic           int_we,
    output logic           int_re,
    input  logic [DW-1:0]  int_rdata,
    input  logic           int_fail,
    output logic [DW-1:0]  resp_rdata,
    output logic           resp_err,
    output logic           err_en
);
    logic [IAW-1:0] addr_q;
    logic [DW-1:0]  buf_q;
    logic           en_q;

    logic is_addr, is_data, is_ctrl, is_none;

    assign is_addr = cmd.valid && (cmd.slot == SLOT_ADDR);
    assign is_data = cmd.valid && (cmd.slot == SLOT_DATA);
    assign is_ctrl = cmd.valid && (cmd.slot == SLOT_CTRL);
    assign is_none = cmd.valid && (cmd.slot == SLOT_NONE);

    assign int_we    = is_data && cmd.we;
    assign int_re    = is_data && !cmd.we;
    assign int_addr  = addr_q;
    assign int_wdata = bus_wdata;
    assign err_en    = en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            buf_q  <= '0;
            en_q   <= 1'b0;
        end else begin
            if (is_addr && cmd.we)
                addr_q <= bus_wdata[IAW-1:0];
            if (is_ctrl && cmd.we)
                en_q <= bus_wdata[ERR_EN_BIT];
            if (int_re)
                buf_q <= int_rdata;
        end
    end

    always_comb begin
        resp_rdata = '0;
        if (cmd.valid && !cmd.we) begin
            case (cmd.slot)
                SLOT_ADDR: resp_rdata = DW'(addr_q);
                SLOT_DATA: resp_rdata = buf_q;
                SLOT_CTRL: resp_rdata[ERR_EN_BIT] = en_q;
                default:   resp_rdata = '0;
            endcase
        end
    end

    assign resp_err = en_q && ((is_data && int_fail) || is_none);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(is_addr && cmd.we) |=> $stable(addr_q));

    // R4
    buf_capture_chk: assert property (@(posedge clk) disable iff (rst)
        int_re |=> (buf_q == $past(int_rdata)));

    // R7
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(is_ctrl && cmd.we) |=> $stable(en_q));

    // R4
    buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !int_re |=> $stable(buf_q));

endmodule

// File: rtl/ibr_response.sv
module ibr_response #(
    parameter int DW   = 32,
    parameter int NWIN = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_sel,
    input  logic                     out_of_range,
    input  logic [NWIN-1:0][DW-1:0]  win_rdata,
    input  logic [NWIN-1:0]          win_err,
    input  logic [NWIN-1:0]          win_en,
    output logic                     bus_ack,
    output logic [DW-1:0]            bus_rdata,
    output logic                     bus_err
);
    logic [DW-1:0] merged_rdata;
    logic          merged_err;

    always_comb begin
        merged_rdata = '0;
        merged_err   = out_of_range && (|win_en);
        for (int w = 0; w < NWIN; w++) begin
            merged_rdata = merged_rdata | win_rdata[w];
            merged_err   = merged_err | win_err[w];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_ack   <= bus_sel;
            bus_rdata <= bus_sel ? merged_rdata : '0;
            bus_err   <= bus_sel && merged_err;
        end
    end

    // R6
    ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
        bus_sel |=> bus_ack);

    // R6
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> !bus_ack);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_ack |-> (bus_rdata == '0 && !bus_err));

endmodule

// File: rtl/ibr_dual_window.sv
module ibr_dual_window
    import ibr_pkg::*;
#(
    parameter int BUS_AW = 8,
    parameter int DW     = 32,
    parameter int IAW    = 16,
    parameter int NWIN   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [BUS_AW-1:0]         bus_addr,
    input  logic [DW-1:0]             bus_wdata,
    output logic                      bus_ack,
    output logic [DW-1:0]             bus_rdata,
    output logic                      bus_err,
    output logic [NWIN-1:0][IAW-1:0]  reg_addr,
    output logic [NWIN-1:0][DW-1:0]   reg_wdata,
    output logic [NWIN-1:0]           reg_we,
    output logic [NWIN-1:0]           reg_re,
    input  logic [NWIN-1:0][DW-1:0]   reg_rdata,
    input  logic [NWIN-1:0]           reg_fail
);
    win_cmd_t [NWIN-1:0]          cmd;
    logic                         out_of_range;
    logic     [NWIN-1:0][DW-1:0]  win_rdata;
    logic     [NWIN-1:0]          win_err;
    logic     [NWIN-1:0]          win_en;

    ibr_decode #(.BUS_AW(BUS_AW), .NWIN(NWIN)) u_decode (
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .cmd          (cmd),
        .out_of_range (out_of_range)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        ibr_window #(.IAW(IAW), .DW(DW)) u_window (
            .clk        (clk),
            .rst        (rst),
            .cmd        (cmd[w]),
            .bus_wdata  (bus_wdata),
            .int_addr   (reg_addr[w]),
            .int_wdata  (reg_wdata[w]),
            .int_we     (reg_we[w]),
            .int_re     (reg_re[w]),
            .int_rdata  (reg_rdata[w]),
            .int_fail   (reg_fail[w]),
            .resp_rdata (win_rdata[w]),
            .resp_err   (win_err[w]),
            .err_en     (win_en[w])
        );
    end

    ibr_response #(.DW(DW), .NWIN(NWIN)) u_response (
        .clk          (clk),
        .rst          (rst),
        .bus_sel      (bus_sel),
        .out_of_range (out_of_range),
        .win_rdata    (win_rdata),
        .win_err      (win_err),
        .win_en       (win_en),
        .bus_ack      (bus_ack),
        .bus_rdata    (bus_rdata),
        .bus_err      (bus_err)
    );

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_we, reg_re}));

    // R3
    strobe_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> ({reg_we, reg_re} == '0));

endmodule

// File: tb/tb_ibr_dual_window.sv
module tb_ibr_dual_window;
    localparam int BUS_AW = 8;
    localparam int DW     = 32;
    localparam int IAW    = 16;
    localparam int NWIN   = 2;

    logic                      clk = 1'b0;
    logic                      rst;
    logic                      bus_sel;
    logic                      bus_wr;
    logic [BUS_AW-1:0]         bus_addr;
    logic [DW-1:0]             bus_wdata;
    logic                      bus_ack;
    logic [DW-1:0]             bus_rdata;
    logic                      bus_err;
    logic [NWIN-1:0][IAW-1:0]  reg_addr;
    logic [NWIN-1:0][DW-1:0]   reg_wdata;
    logic [NWIN-1:0]           reg_we;
    logic [NWIN-1:0]           reg_re;
    logic [NWIN-1:0][DW-1:0]   reg_rdata;
    logic [NWIN-1:0]           reg_fail;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ibr_dual_window #(.BUS_AW(BUS_AW), .DW(DW), .IAW(IAW), .NWIN(NWIN)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata), .reg_fail(reg_fail)
    );

    // Internal register model: data encodes window and address,
    // failure for internal addresses whose high byte is 0xEE
    function automatic logic [DW-1:0] model_rd(input int w, input logic [IAW-1:0] a);
        return {8'h5A + 8'(w), 8'(w * 17), a ^ 16'h0F0F};
    endfunction

    always_comb begin
        for (int w = 0; w < NWIN; w++) begin
            reg_rdata[w] = model_rd(w, reg_addr[w]);
            reg_fail[w]  = (reg_addr[w][15:8] == 8'hEE);
        end
    end

    // Snapshot of the internal side during the request cycle
    logic [NWIN-1:0]          s_we, s_re;
    logic [NWIN-1:0][IAW-1:0] s_addr;
    logic [NWIN-1:0][DW-1:0]  s_wdata;
    logic                     r_ack, r_err;
    logic [DW-1:0]            r_rdata;
    logic [DW-1:0]            exp_buf [NWIN];

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit we, input logic [BUS_AW-1:0] off, input logic [DW-1:0] wd);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = we; bus_addr = off; bus_wdata = wd;
        #1;
        s_we = reg_we; s_re = reg_re; s_addr = reg_addr; s_wdata = reg_wdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        #1;
        r_ack = bus_ack; r_err = bus_err; r_rdata = bus_rdata;
        // R6: every access answered one cycle later
        chk(r_ack === 1'b1, "R6 ack", DW'(r_ack), 1);
    endtask

    task automatic set_addr(input int w, input logic [IAW-1:0] a, input logic [15:0] junk);
        for (int k = 0; k < 2; k++) begin
            acc(1'b1, BUS_AW'(16 * w), {junk, a});
            // R2: address writes raise no internal strobe
            chk(s_we == '0 && s_re == '0, "R2 no strobe", DW'({s_we, s_re}), 0);
        end
    endtask

    task automatic data_read(input int w, input logic [IAW-1:0] a, input string tag);
        acc(1'b0, BUS_AW'(16 * w + 4), '0);
        chk(s_re == NWIN'(1 << w) && s_addr[w] == a, {tag, " strobe"},
            DW'(s_addr[w]), DW'(a));
        chk(r_rdata == exp_buf[w], {tag, " prefetch"}, r_rdata, exp_buf[w]);
        exp_buf[w] = model_rd(w, a);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        rst = 1'b1;
        for (int w = 0; w < NWIN; w++) exp_buf[w] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R6: idle outputs quiet
        chk(bus_ack == 0 && bus_rdata == 0 && bus_err == 0, "R6 idle", bus_rdata, 0);

        // R1: reset state visible through every defined slot
        for (int w = 0; w < NWIN; w++) begin
            acc(1'b0, BUS_AW'(16 * w), '0);
            chk(r_rdata == 0, "R1 addr latch", r_rdata, 0);
            acc(1'b0, BUS_AW'(16 * w + 8), '0);
            chk(r_rdata == 0, "R1 control", r_rdata, 0);
            data_read(w, 16'h0000, "R1 buffer");
        end

        // R2 R4 R5 R3: sweep over internal addresses in each window
        for (int w = 0; w < NWIN; w++) begin
            for (int i = 0; i < 40; i++) begin
                logic [IAW-1:0] a;
                a = IAW'(i * 1637 + w * 211);
                if (i == 39) a = 16'hFFFF;
                set_addr(w, a, 16'hBEEF ^ 16'(i));
                acc(1'b0, BUS_AW'(16 * w), '0);
                chk(r_rdata == DW'(a), "R2 addr readback", r_rdata, DW'(a));
                data_read(w, a, "R4 first read");
                data_read(w, a, "R5 second read");
                acc(1'b1, BUS_AW'(16 * w + 4), 32'hD00D_0000 + 32'(i));
                chk(s_we == NWIN'(1 << w) && s_re == '0 && s_addr[w] == a &&
                    s_wdata[w] == 32'hD00D_0000 + 32'(i), "R3 write strobe",
                    s_wdata[w], 32'hD00D_0000 + 32'(i));
            end
        end

        // R7: only bit 15 of control is kept
        acc(1'b1, 8'h08, 32'hFFFF_FFFF);
        acc(1'b0, 8'h08, '0);
        chk(r_rdata == 32'h0000_8000, "R7 ctrl set", r_rdata, 32'h0000_8000);
        acc(1'b1, 8'h08, 32'hFFFF_7FFF);
        acc(1'b0, 8'h08, '0);
        chk(r_rdata == 32'h0, "R7 ctrl clear", r_rdata, 0);

        // R8: internal failure with and without enable
        set_addr(0, 16'hEE01, 16'h0);
        acc(1'b0, 8'h04, '0);
        exp_buf[0] = model_rd(0, 16'hEE01);
        chk(r_err == 1'b0, "R8 fail disabled", DW'(r_err), 0);
        acc(1'b1, 8'h08, 32'h0000_8000);
        acc(1'b0, 8'h04, '0);
        chk(r_err == 1'b1, "R8 fail enabled read", DW'(r_err), 1);
        acc(1'b1, 8'h04, 32'h1);
        chk(r_err == 1'b1, "R8 fail enabled write", DW'(r_err), 1);
        set_addr(0, 16'h1234, 16'h0);
        acc(1'b0, 8'h04, '0);
        exp_buf[0] = model_rd(0, 16'h1234);
        chk(r_err == 1'b0, "R8 good access", DW'(r_err), 0);
        acc(1'b1, 8'h08, 32'h0);

        // R9: every byte offset under both enable settings
        for (int en = 0; en < 2; en++) begin
            acc(1'b1, 8'h18, en ? 32'h8000 : 32'h0);
            for (int off = 0; off < 256; off++) begin
                bit defined, exp_e;
                logic [DW-1:0] e;
                defined = (off < 16 * NWIN) && (off[3:0] inside {4'h0, 4'h4, 4'h8});
                if (defined) continue;
                acc(1'b0, BUS_AW'(off), '0);
                // window 1 enable governs its own holes and everything above
                exp_e = (en == 1) && (off >= 16);
                chk(r_rdata == 0, "R9 hole reads zero", r_rdata, 0);
                chk(r_err == exp_e, "R9 hole error", DW'(r_err), DW'(exp_e));
                acc(1'b1, BUS_AW'(off), 32'hFFFF_FFFF);
                chk(s_we == '0 && s_re == '0, "R9 hole no strobe", DW'({s_we, s_re}), 0);
                e = 0;
            end
        end
        acc(1'b1, 8'h18, 32'h0);
        // R9: hole writes left latches and enables untouched
        acc(1'b0, 8'h00, '0);
        chk(r_rdata == 32'h1234, "R9 addr kept", r_rdata, 32'h1234);
        acc(1'b0, 8'h08, '0);
        chk(r_rdata == 0, "R9 ctrl kept", r_rdata, 0);

        // R10: interleaved windows keep their own state
        set_addr(0, 16'h0A0A, 16'h0);
        set_addr(1, 16'h0B0B, 16'h0);
        data_read(0, 16'h0A0A, "R10 w0 first");
        data_read(1, 16'h0B0B, "R10 w1 first");
        data_read(0, 16'h0A0A, "R10 w0 second");
        data_read(1, 16'h0B0B, "R10 w1 second");
        acc(1'b0, 8'h00, '0);
        chk(r_rdata == 32'h0A0A, "R10 w0 addr", r_rdata, 32'h0A0A);
        acc(1'b0, 8'h10, '0);
        chk(r_rdata == 32'h0B0B, "R10 w1 addr", r_rdata, 32'h0B0B);

        // R1: reset clears state again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int w = 0; w < NWIN; w++) exp_buf[w] = '0;
        acc(1'b0, 8'h10, '0);
        chk(r_rdata == 0, "R1 re-reset addr", r_rdata, 0);
        data_read(1, 16'h0000, "R1 re-reset buffer");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule